// File: doc/BRIEF.md
# Error-compensated shift-add tree

This block forms a weighted sum of six signed partial words in one combinational pass. Word k carries a weight of 2^-k. Each word is shifted down by k places, so every bit that falls below the integer LSB is dropped. All six shifted words then enter a balanced adder tree together, so the block never steps through them one at a time.

Truncation alone always rounds the sum down, by nearly one LSB for each shifted word. To reduce that bias, the block looks at the highest discarded bit of every shifted word. These are the half-LSB guard bits. The block counts how many are set, halves the count, and feeds the result into the tree as a seventh leaf. The total is clamped to a 9-bit signed result. An optional output register adds one cycle of latency and carries a valid flag alongside the sum.

Top module: `ecat_sum_tree`

## Requirements
- R1: `in_words` packs word k (k = 0..5) as a signed two's-complement 9-bit value at bits [9k+8:9k], and word k contributes with weight 2^-k.
- R2: Each word is truncated by an arithmetic right shift of k places, which is floor(word / 2^k), before it is summed. With only one nonzero word, the output equals that floor value.
- R3: A compensation term of floor(n/2) is added to the sum. Here n is the number of words k >= 1 whose bit k-1 is set.
- R4: The result saturates to the 9-bit signed range: values above 255 give 255 and values below -256 give -256.
- R5: Internal sums are wide enough that no combination of inputs wraps before saturation. Large sums of either sign therefore saturate on the correct side.
- R6: With the output register enabled, `out_valid` equals `in_valid` one clock later, and `out_sum` shows the result for the inputs sampled at that edge.
- R7: While `in_valid` is low, `out_sum` holds its previous value, whatever `in_words` carries.
- R8: During reset, `out_valid` is 0 and `out_sum` is 0.
- R9: Whenever neither result saturates, the absolute error of the output against the exact weighted sum is no larger than that of plain truncation without compensation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input words are valid this cycle |
| in_words | input | 54 | Six packed signed 9-bit partial words, word k at bits [9k+8:9k] |
| out_valid | output | 1 | `out_sum` holds a new result |
| out_sum | output | 9 | Saturated, compensated weighted sum, signed |

## Verification
Sweeping one word at a time through all of its values, with every other word at zero, isolates the per-word shift and floor. A single guard bit never reaches the compensation threshold, so these vectors reveal a wrong shift amount or a wrong rounding direction. Running through all 32 combinations of guard bits, on words that truncate to zero, isolates the compensation count and its halving. Words at full scale in each direction, and at alternating extremes, separate correct saturation from an internal wrap. Long runs of random vectors check exact values against an arithmetic model, and compare the error against uncompensated truncation. Cycles with `in_valid` low while the words change show whether the output holds.

// File: rtl/ecat_pkg.sv
package ecat_pkg;
    // Default geometry shared by the tree and its checker.
    localparam int DEF_WORD_W  = 9;
    localparam int DEF_N_WORDS = 6;
    localparam int DEF_OUT_W   = 9;
endpackage

// File: rtl/ecat_trunc_row.sv
// Shifts word k down by k places (floor) and extracts its half-LSB guard bit.
module ecat_trunc_row #(
    parameter int WORD_W  = ecat_pkg::DEF_WORD_W,
    parameter int N_WORDS = ecat_pkg::DEF_N_WORDS,
    parameter int SUM_W   = WORD_W + 4
) (
    input  logic [N_WORDS*WORD_W-1:0] words,
    output logic [N_WORDS*SUM_W-1:0]  kept_flat,
    output logic [N_WORDS-1:0]        guard_bits
);
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic signed [WORD_W-1:0] w;
        logic signed [SUM_W-1:0]  wx;
        assign w  = words[k*WORD_W +: WORD_W];
        assign wx = w;
        assign kept_flat[k*SUM_W +: SUM_W] = wx >>> k;
        if (k == 0) begin : g_nodrop
            assign guard_bits[k] = 1'b0;
        end else begin : g_drop
            assign guard_bits[k] = w[k-1];
        end
    end
endmodule

// File: rtl/ecat_comp.sv
// Carry estimate from the truncated region: half the count of guard bits set.
module ecat_comp #(
    parameter int N_WORDS = ecat_pkg::DEF_N_WORDS,
    parameter int SUM_W   = 13
) (
    input  logic [N_WORDS-1:0]       guard_bits,
    output logic signed [SUM_W-1:0]  comp
);
    localparam int CNT_W = $clog2(N_WORDS + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            cnt = cnt + CNT_W'(guard_bits[i]);
        end
        comp = SUM_W'(cnt >> 1);
    end
endmodule

// File: rtl/ecat_adder_tree.sv
// Balanced binary adder tree, heap-indexed, leaves padded to a power of two.
module ecat_adder_tree #(
    parameter int N_LEAVES = 7,
    parameter int SUM_W    = 13
) (
    input  logic [N_LEAVES*SUM_W-1:0] leaves_flat,
    output logic signed [SUM_W-1:0]   total
);
    localparam int LVL = (N_LEAVES > 1) ? $clog2(N_LEAVES) : 0;
    localparam int PAD = 1 << LVL;

    logic signed [SUM_W-1:0] node [2*PAD-1];

    always_comb begin
        for (int i = 0; i < PAD; i++) begin
            if (i < N_LEAVES) node[PAD-1+i] = leaves_flat[i*SUM_W +: SUM_W];
            else              node[PAD-1+i] = '0;
        end
        for (int i = PAD - 2; i >= 0; i--) begin
            node[i] = node[2*i+1] + node[2*i+2];
        end
        total = node[0];
    end
endmodule

// File: rtl/ecat_sum_tree.sv
module ecat_sum_tree #(
    parameter int WORD_W  = ecat_pkg::DEF_WORD_W,
    parameter int N_WORDS = ecat_pkg::DEF_N_WORDS,
    parameter int OUT_W   = ecat_pkg::DEF_OUT_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_WORDS*WORD_W-1:0] in_words,
    output logic                      out_valid,
    output logic [OUT_W-1:0]          out_sum
);
    localparam int CNT_W    = $clog2(N_WORDS + 1);
    localparam int SUM_W    = WORD_W + CNT_W + 1;
    localparam int N_LEAVES = N_WORDS + 1;
    localparam int MAX_I    = (2 ** (OUT_W - 1)) - 1;
    localparam int MIN_I    = -(2 ** (OUT_W - 1));

    typedef struct packed {
        logic                    valid;
        logic signed [OUT_W-1:0] sum;
    } out_t;

    logic [N_WORDS*SUM_W-1:0]  kept_flat;
    logic [N_WORDS-1:0]        guard_bits;
    logic signed [SUM_W-1:0]   comp;
    logic signed [SUM_W-1:0]   total;
    logic signed [OUT_W-1:0]   sat_val;
    out_t                      st_d, st_q;

    ecat_trunc_row #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .SUM_W(SUM_W)) u_row (
        .words      (in_words),
        .kept_flat  (kept_flat),
        .guard_bits (guard_bits)
    );

    ecat_comp #(.N_WORDS(N_WORDS), .SUM_W(SUM_W)) u_comp (
        .guard_bits (guard_bits),
        .comp       (comp)
    );

    // Compensation enters the tree as one more leaf.
    ecat_adder_tree #(.N_LEAVES(N_LEAVES), .SUM_W(SUM_W)) u_tree (
        .leaves_flat ({comp, kept_flat}),
        .total       (total)
    );

    always_comb begin
        if (int'(total) > MAX_I)      sat_val = OUT_W'(MAX_I);
        else if (int'(total) < MIN_I) sat_val = OUT_W'(MIN_I);
        else                          sat_val = OUT_W'(total);
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.sum = sat_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (REG_OUT) begin : g_reg
        assign out_valid = st_q.valid;
        assign out_sum   = st_q.sum;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_sum   = sat_val;
    end
endmodule

// File: rtl/ecat_sum_tree_chk.sv
module ecat_sum_tree_chk #(
    parameter int WORD_W  = ecat_pkg::DEF_WORD_W,
    parameter int N_WORDS = ecat_pkg::DEF_N_WORDS,
    parameter int OUT_W   = ecat_pkg::DEF_OUT_W,
    parameter bit REG_OUT = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [N_WORDS*WORD_W-1:0] in_words,
    input logic                      out_valid,
    input logic [OUT_W-1:0]          out_sum
);
    localparam int MAX_I    = (2 ** (OUT_W - 1)) - 1;
    localparam int MIN_I    = -(2 ** (OUT_W - 1));
    localparam int MAX_COMP = (N_WORDS - 1) / 2;

    // Saturated sum of truncated words without any compensation.
    function automatic int plain_sat(input logic [N_WORDS*WORD_W-1:0] v);
        int acc;
        acc = 0;
        for (int k = 0; k < N_WORDS; k++) begin
            logic signed [WORD_W-1:0] x;
            x = v[k*WORD_W +: WORD_W];
            acc += int'(x >>> k);
        end
        if (acc > MAX_I) acc = MAX_I;
        if (acc < MIN_I) acc = MIN_I;
        return acc;
    endfunction

    int plain_now;
    int out_i;
    logic all_max;
    assign plain_now = plain_sat(in_words);
    assign out_i     = int'($signed(out_sum));
    assign all_max   = (in_words == {N_WORDS{1'b0, {(WORD_W-1){1'b1}}}});

    if (REG_OUT) begin : g_reg
        assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_sum));
        assert_comp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_i >= $past(plain_now)) && (out_i <= $past(plain_now) + MAX_COMP));
        assert_zero_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_words == '0) |=> out_sum == '0);
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && all_max) |=> out_i == MAX_I);
    end else begin : g_comb
        assert_comp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (out_i >= plain_now) && (out_i <= plain_now + MAX_COMP));
        assert_zero_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_words == '0) |-> out_sum == '0);
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && all_max) |-> out_i == MAX_I);
        assert_valid_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
    end
endmodule

bind ecat_sum_tree ecat_sum_tree_chk #(
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .OUT_W(OUT_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/ecat_sum_tree_test.sv
module ecat_sum_tree_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WORD_W  = 9;
    localparam int N_WORDS = 6;
    localparam int OUT_W   = 9;
    localparam int MAX_I   = 255;
    localparam int MIN_I   = -256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N_WORDS*WORD_W-1:0] in_words = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_sum;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecat_sum_tree #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .OUT_W(OUT_W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic int fmod(int a, int d);
        int r = a % d;
        if (r < 0) r += d;
        return r;
    endfunction

    function automatic int clampv(int v);
        if (v > MAX_I) return MAX_I;
        if (v < MIN_I) return MIN_I;
        return v;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Drive one vector, check value, valid and error bound one cycle later.
    task automatic run_vec(string req, int w [N_WORDS]);
        int unc, cnt, d, exact, expc, expu;
        unc = 0; cnt = 0; exact = 0;
        @(negedge clk);
        for (int k = 0; k < N_WORDS; k++) begin
            in_words[k*WORD_W +: WORD_W] = WORD_W'(w[k]);
            d = 1 << k;
            unc += (w[k] - fmod(w[k], d)) / d;
            if (k > 0 && fmod(w[k], d) >= d / 2) cnt++;
            exact += w[k] * (1 << (N_WORDS - 1 - k));
        end
        in_valid = 1'b1;
        expc = clampv(unc + cnt / 2);
        expu = clampv(unc);
        @(negedge clk);
        check("R6 valid", int'(out_valid), 1);
        check(req, int'($signed(out_sum)), expc);
        if (expc == unc + cnt / 2 && expu == unc && expc > MIN_I && expc < MAX_I) begin
            total++;
            if (absv(int'($signed(out_sum)) * 32 - exact) > absv(expu * 32 - exact)) begin
                bad++;
                $display("FAIL R9: error %0d/32 expected at most %0d/32",
                         absv(int'($signed(out_sum)) * 32 - exact), absv(expu * 32 - exact));
            end
        end
    endtask

    task automatic idle_check();
        int held;
        held = int'($signed(out_sum));
        @(negedge clk);
        in_valid = 1'b0;
        in_words = {$urandom, $urandom};
        @(negedge clk);
        check("R7 idle valid", int'(out_valid), 0);
        check("R7 hold", int'($signed(out_sum)), held);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        int w [N_WORDS];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 valid", int'(out_valid), 0);
        check("R8 sum", int'(out_sum), 0);
        rst_n = 1'b1;

        // R1/R2: one nonzero word at a time, full value range.
        for (int k = 0; k < N_WORDS; k++) begin
            for (int v = MIN_I; v <= MAX_I; v++) begin
                foreach (w[j]) w[j] = 0;
                w[k] = v;
                run_vec("R2", w);
            end
        end
        idle_check();

        // R3: every combination of guard bits on words that truncate to zero.
        for (int m = 0; m < 32; m++) begin
            w[0] = 0;
            for (int k = 1; k < N_WORDS; k++) w[k] = m[k-1] ? (1 << (k - 1)) : 0;
            run_vec("R3", w);
        end
        idle_check();

        // R4/R5: full scale and alternating extremes.
        foreach (w[j]) w[j] = MAX_I;
        run_vec("R5", w);
        foreach (w[j]) w[j] = MIN_I;
        run_vec("R5", w);
        foreach (w[j]) w[j] = (j % 2 == 0) ? MAX_I : MIN_I;
        run_vec("R4", w);
        foreach (w[j]) w[j] = 0;
        w[0] = MAX_I; w[1] = 2;
        run_vec("R4", w);
        w[0] = MIN_I; w[1] = -3;
        run_vec("R4", w);
        idle_check();

        // R9 and exact values on random words.
        for (int n = 0; n < 20000; n++) begin
            foreach (w[j]) w[j] = int'($urandom_range(511)) - 256;
            run_vec("R3 random", w);
            if (n % 2000 == 0) idle_check();
        end

        done = 1;
        summary();
    end
endmodule